// File: doc/BRIEF.md
# SDRAM Read Burst Pipeline

This block models the read data path of a single-data-rate synchronous DRAM. A READ command carries a bank and a starting column. It runs a burst of column words through a pipeline whose depth is set by the programmed CAS latency. The words then appear on the data output together with a drive-enable flag. When the enable is low the data lines are treated as released (high impedance), and the block parks them at zero. A computed word array stands in for the storage cells, so every bank and column has a known content.

The burst runs on its own through NOP cycles. It ends after its fixed length, or in full-page mode it wraps around the page and runs until the next READ. Any new READ, on any cycle, cuts the running burst short. Its data follows the last word that was kept with no idle cycle between them. The mode register holds the CAS latency and the burst length. It changes only while no read data is pending.

Top module: `rdburst_pipe`

## Requirements
- R1: After a synchronous active-low reset, `dq_oe` is 0 and `dq` is 0. The mode is CAS latency 3 with burst length code 2 (four words).
- R2: Suppose a READ is sampled at rising edge E with CAS latency CL (2 or 3). Its first word is driven with `dq_oe`=1 from edge E+CL-1 until edge E+CL, so a receiver captures it at edge E+CL. Each following word comes one cycle later.
- R3: The word at bank b and column c is {b[1:0], 5'b10101, c[8:0]} (bank in bits 15:14, column in bits 8:0).
- R4: Burst length codes 0, 1, 2 and 3 give 1, 2, 4 and 8 words. Let the burst length be L and the start column s. Word i reads column (s & ~(L-1)) | ((s+i) & (L-1)), so the order wraps inside the aligned block. NOP cycles do not stop a burst.
- R5: Burst length code 7 selects full page. Word i reads column (s+i) mod 512, and the burst keeps running until another READ arrives.
- R6: When a burst ends and no other READ follows, `dq_oe` drops to 0 and `dq` returns to 0 in the cycle after the last word.
- R7: A READ sampled during a burst stops the old burst. The old burst keeps only the words it produced before that edge, and the new burst's first word follows them directly. A READ issued CL-1 cycles before the last wanted word therefore gives gapless data.
- R8: A READ is accepted on every cycle, to the same bank or to a different one.
- R9: A mode write is ignored if a READ is sampled at the same edge, or if any word of an earlier READ is still in flight or on `dq`.
- R10: A mode write with a CAS latency other than 2 or 3, or with burst length code 4, 5 or 6, is ignored as a whole.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_rd | input | 1 | READ command strobe, sampled each rising edge |
| cmd_bank | input | 2 | Bank of the READ |
| cmd_col | input | 9 | Starting column of the READ |
| mode_wr | input | 1 | Mode register write strobe |
| mode_cl | input | 2 | CAS latency to write (2 or 3) |
| mode_bl | input | 3 | Burst length code to write (0..3 fixed, 7 full page) |
| dq | output | 16 | Read data, zero while released |
| dq_oe | output | 1 | Data drive enable |

## Verification
The bench targets READs that land exactly CL-1 cycles before the last wanted word, READs on every cycle, and truncation one word into a burst. A pipeline that mishandled these would leave a one-cycle hole, repeat a word, or let the old burst's words leak past the new ones. It walks start columns near the end of an aligned block and near column 511. A wrong wrap would read outside the block, or step to column 512 instead of 0. Mode writes are tried during a burst, on the same edge as a READ, and with reserved codes. A block that accepted any of them would shift the latency or the length of the next burst, and that shows up on `dq`.

// File: rtl/rdb_pkg.sv
package rdb_pkg;

    // Burst length codes as written through the mode port.
    typedef enum logic [2:0] {
        BL_ONE   = 3'd0,
        BL_TWO   = 3'd1,
        BL_FOUR  = 3'd2,
        BL_EIGHT = 3'd3,
        BL_PAGE  = 3'd7
    } bl_code_e;

    // True for the burst length codes the block supports.
    function automatic logic bl_code_ok(input logic [2:0] code);
        return (code <= 3'd3) || (code == 3'd7);
    endfunction

endpackage

// File: rtl/rdb_word_src.sv
// rdb_word_src: computed stand-in for the storage array.
// Gives the word at (bank, column) as {bank, alternating pattern, column}.
// Assumes DQ_W is wider than BANK_W + COL_W.
module rdb_word_src #(
    parameter int BANK_W = 2,
    parameter int COL_W  = 9,
    parameter int DQ_W   = 16
) (
    input  logic [BANK_W-1:0] bank,
    input  logic [COL_W-1:0]  col,
    output logic [DQ_W-1:0]   word
);
    localparam int PAT_W = DQ_W - BANK_W - COL_W;

    logic [PAT_W-1:0] pat;

    // Pattern bits: ones at even positions.
    for (genvar i = 0; i < PAT_W; i++) begin : g_pat
        assign pat[i] = ((i % 2) == 0);
    end

    assign word = {bank, pat, col};
endmodule

// File: rtl/rdb_mode_reg.sv
// rdb_mode_reg: holds CAS latency and burst length code.
// Takes a write only when it is legal, no READ is sampled and nothing is busy.
// Assumes CL_MIN <= CL_MAX and that CL_W can hold CL_MAX.
module rdb_mode_reg
    import rdb_pkg::*;
#(
    parameter int CL_MIN = 2,
    parameter int CL_MAX = 3,
    parameter int CL_W   = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            mode_wr,
    input  logic [CL_W-1:0] mode_cl,
    input  logic [2:0]      mode_bl,
    input  logic            busy,
    input  logic            cmd_rd,
    output logic [CL_W-1:0] cl,
    output bl_code_e        bl
);
    localparam logic [CL_W-1:0] CL_LO = CL_W'(CL_MIN);
    localparam logic [CL_W-1:0] CL_HI = CL_W'(CL_MAX);

    logic legal;
    logic take;

    // Decide whether this cycle's write may land.
    always_comb begin
        legal = (mode_cl >= CL_LO) && (mode_cl <= CL_HI) && bl_code_ok(mode_bl);
        take  = mode_wr && legal && !busy && !cmd_rd;
    end

    // Mode storage with reset defaults.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cl <= CL_HI;
            bl <= BL_FOUR;
        end else if (take) begin
            cl <= mode_cl;
            bl <= bl_code_e'(mode_bl);
        end
    end
endmodule

// File: rtl/rdb_burst_engine.sv
// rdb_burst_engine: walks the column sequence of the current burst.
// Each cycle it is active, it presents one (bank, column) pair.
// A READ reloads it at once. This is how truncation is done.
// Assumes COL_W >= 3 so that an eight-word block fits.
module rdb_burst_engine
    import rdb_pkg::*;
#(
    parameter int BANK_W = 2,
    parameter int COL_W  = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_rd,
    input  logic [BANK_W-1:0] cmd_bank,
    input  logic [COL_W-1:0]  cmd_col,
    input  bl_code_e          bl,
    output logic              active,
    output logic              full,
    output logic [BANK_W-1:0] bank,
    output logic [COL_W-1:0]  col,
    output logic [COL_W-1:0]  remain
);
    logic [COL_W-1:0] mask_n;
    logic [COL_W-1:0] mask_q;
    logic [COL_W-1:0] col_nx;

    // Wrap mask for the requested length; full page uses the whole page.
    always_comb begin
        case (bl)
            BL_ONE:   mask_n = '0;
            BL_TWO:   mask_n = COL_W'(1);
            BL_FOUR:  mask_n = COL_W'(3);
            BL_EIGHT: mask_n = COL_W'(7);
            default:  mask_n = '1;
        endcase
    end

    // Next column: increment inside the aligned block.
    always_comb begin
        col_nx = (col & ~mask_q) | ((col + COL_W'(1)) & mask_q);
    end

    // Burst state: load on READ, advance while active, stop at the end.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active <= 1'b0;
            full   <= 1'b0;
            bank   <= '0;
            col    <= '0;
            remain <= '0;
            mask_q <= '0;
        end else if (cmd_rd) begin
            active <= 1'b1;
            full   <= (bl == BL_PAGE);
            bank   <= cmd_bank;
            col    <= cmd_col;
            remain <= mask_n;
            mask_q <= mask_n;
        end else if (active) begin
            if (!full && (remain == '0)) begin
                active <= 1'b0;
            end else begin
                col <= col_nx;
                if (!full) begin
                    remain <= remain - COL_W'(1);
                end
            end
        end
    end
endmodule

// File: rtl/rdb_lat_pipe.sv
// rdb_lat_pipe: delays the word stream to honour the CAS latency.
// A chain of CL_MAX-2 stages is tapped at CL-2. The last stage is the output register.
// Assumes CL_MAX >= 3 and that cl changes only while the chain is empty.
module rdb_lat_pipe #(
    parameter int DQ_W   = 16,
    parameter int CL_MAX = 3,
    parameter int CL_W   = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            in_vld,
    input  logic [DQ_W-1:0] in_data,
    input  logic [CL_W-1:0] cl,
    output logic [DQ_W-1:0] dq,
    output logic            dq_oe,
    output logic            busy
);
    localparam int NSTG = CL_MAX - 2;

    logic [NSTG-1:0] stg_v;
    logic [DQ_W-1:0] stg_d [NSTG];
    logic [NSTG:0]   tap_v;
    logic [DQ_W-1:0] tap_d [NSTG+1];
    logic [CL_W-1:0] sel;
    logic            sel_v;
    logic [DQ_W-1:0] sel_d;

    // Tap vector: tap 0 is the engine, tap k is stage k-1.
    always_comb begin
        tap_v    = {stg_v, in_vld};
        tap_d[0] = in_data;
        for (int k = 0; k < NSTG; k++) begin
            tap_d[k+1] = stg_d[k];
        end
    end

    // Delay chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stg_v <= '0;
            for (int k = 0; k < NSTG; k++) begin
                stg_d[k] <= '0;
            end
        end else begin
            stg_v <= tap_v[NSTG-1:0];
            for (int k = 0; k < NSTG; k++) begin
                stg_d[k] <= tap_d[k];
            end
        end
    end

    // Pick the tap that matches the programmed latency.
    always_comb begin
        sel   = cl - CL_W'(2);
        sel_v = tap_v[0];
        sel_d = tap_d[0];
        for (int k = 1; k <= NSTG; k++) begin
            if (sel == CL_W'(k)) begin
                sel_v = tap_v[k];
                sel_d = tap_d[k];
            end
        end
    end

    // Output register: drives data only while a word is valid.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dq_oe <= 1'b0;
            dq    <= '0;
        end else begin
            dq_oe <= sel_v;
            dq    <= sel_v ? sel_d : '0;
        end
    end

    // Any word still in the chain or on the output keeps the block busy.
    assign busy = (|stg_v) | dq_oe;
endmodule

// File: rtl/rdburst_pipe.sv
// rdburst_pipe: read data path of a single-data-rate synchronous DRAM.
// Chains the mode register, burst engine, word source and latency pipeline.
// Assumes one READ at most per cycle and that bank activation is handled elsewhere.
module rdburst_pipe
    import rdb_pkg::*;
#(
    parameter int BANK_W = 2,
    parameter int COL_W  = 9,
    parameter int DQ_W   = 16,
    parameter int CL_MAX = 3,
    localparam int CL_W  = $clog2(CL_MAX + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_rd,
    input  logic [BANK_W-1:0] cmd_bank,
    input  logic [COL_W-1:0]  cmd_col,
    input  logic              mode_wr,
    input  logic [CL_W-1:0]   mode_cl,
    input  logic [2:0]        mode_bl,
    output logic [DQ_W-1:0]   dq,
    output logic              dq_oe
);
    logic [CL_W-1:0]   cur_cl;
    bl_code_e          cur_bl;
    logic              eng_active;
    logic              eng_full;
    logic [BANK_W-1:0] eng_bank;
    logic [COL_W-1:0]  eng_col;
    logic [COL_W-1:0]  eng_remain;
    logic [DQ_W-1:0]   eng_word;
    logic              pipe_busy;
    logic              busy;

    // Busy spans the engine and every word in flight.
    assign busy = eng_active | pipe_busy;

    rdb_mode_reg #(
        .CL_MIN (2),
        .CL_MAX (CL_MAX),
        .CL_W   (CL_W)
    ) u_mode (
        .clk     (clk),
        .rst_n   (rst_n),
        .mode_wr (mode_wr),
        .mode_cl (mode_cl),
        .mode_bl (mode_bl),
        .busy    (busy),
        .cmd_rd  (cmd_rd),
        .cl      (cur_cl),
        .bl      (cur_bl)
    );

    rdb_burst_engine #(
        .BANK_W (BANK_W),
        .COL_W  (COL_W)
    ) u_eng (
        .clk      (clk),
        .rst_n    (rst_n),
        .cmd_rd   (cmd_rd),
        .cmd_bank (cmd_bank),
        .cmd_col  (cmd_col),
        .bl       (cur_bl),
        .active   (eng_active),
        .full     (eng_full),
        .bank     (eng_bank),
        .col      (eng_col),
        .remain   (eng_remain)
    );

    rdb_word_src #(
        .BANK_W (BANK_W),
        .COL_W  (COL_W),
        .DQ_W   (DQ_W)
    ) u_src (
        .bank (eng_bank),
        .col  (eng_col),
        .word (eng_word)
    );

    rdb_lat_pipe #(
        .DQ_W   (DQ_W),
        .CL_MAX (CL_MAX),
        .CL_W   (CL_W)
    ) u_pipe (
        .clk     (clk),
        .rst_n   (rst_n),
        .in_vld  (eng_active),
        .in_data (eng_word),
        .cl      (cur_cl),
        .dq      (dq),
        .dq_oe   (dq_oe),
        .busy    (pipe_busy)
    );
endmodule

// File: rtl/rdb_checker.sv
// rdb_checker: protocol properties of rdburst_pipe, attached by bind.
// Observes only; drives nothing back into the design.
module rdb_checker #(
    parameter int COL_W  = 9,
    parameter int DQ_W   = 16,
    parameter int CL_MAX = 3,
    parameter int CL_W   = 2
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cmd_rd,
    input logic             busy,
    input logic             eng_active,
    input logic             eng_full,
    input logic [COL_W-1:0] eng_remain,
    input logic [CL_W-1:0]  cur_cl,
    input logic [2:0]       cur_bl,
    input logic [DQ_W-1:0]  dq,
    input logic             dq_oe
);
    // R9: the mode does not move while busy or while a READ is sampled.
    a_r9_mode_locked: assert property (@(posedge clk) disable iff (!rst_n)
        (busy || cmd_rd) |=> ($stable(cur_cl) && $stable(cur_bl)));

    // R10: only legal latencies are ever held.
    a_r10_cl_legal: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_cl >= CL_W'(2)) && (cur_cl <= CL_W'(CL_MAX)));

    // R10: only legal burst codes are ever held.
    a_r10_bl_legal: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_bl <= 3'd3) || (cur_bl == 3'd7));

    // R7: a READ always leaves a running burst behind it.
    a_r7_read_starts: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_rd |=> eng_active);

    // R4: a fixed burst on its last word stops unless a READ arrives.
    a_r4_fixed_stops: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_active && !eng_full && (eng_remain == '0) && !cmd_rd) |=> !eng_active);

    // R5: a full-page burst never stops by itself.
    a_r5_page_runs: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_active && eng_full) |=> eng_active);

    // R6: released data lines sit at zero.
    a_r6_quiet_lines: assert property (@(posedge clk) disable iff (!rst_n)
        !dq_oe |-> (dq == '0));
endmodule

bind rdburst_pipe rdb_checker #(
    .COL_W  (COL_W),
    .DQ_W   (DQ_W),
    .CL_MAX (CL_MAX),
    .CL_W   (CL_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cmd_rd     (cmd_rd),
    .busy       (busy),
    .eng_active (eng_active),
    .eng_full   (eng_full),
    .eng_remain (eng_remain),
    .cur_cl     (cur_cl),
    .cur_bl     (cur_bl),
    .dq         (dq),
    .dq_oe      (dq_oe)
);

// File: tb/tb_rdburst_pipe.sv
// tb_rdburst_pipe: per-cycle comparison of dq/dq_oe against a slot schedule
// built from the requirements. A vector table is followed by directed tests.
module tb_rdburst_pipe;
    localparam int NSL  = 4096;
    localparam int NVEC = 15;

    // Vector: {cl[31:30], bl code[29:27], bank[26:25], col[24:16], nop gap[15:0]}
    localparam logic [31:0] VEC [NVEC] = '{
        {2'd3, 3'd2, 2'd1, 9'h005, 16'd6},
        {2'd3, 3'd2, 2'd2, 9'h00E, 16'd3},
        {2'd3, 3'd2, 2'd3, 9'h101, 16'd1},
        {2'd3, 3'd2, 2'd0, 9'h1FF, 16'd0},
        {2'd3, 3'd2, 2'd1, 9'h0A2, 16'd8},
        {2'd2, 3'd3, 2'd2, 9'h03D, 16'd10},
        {2'd2, 3'd0, 2'd3, 9'h111, 16'd0},
        {2'd2, 3'd0, 2'd0, 9'h112, 16'd0},
        {2'd2, 3'd0, 2'd1, 9'h1FE, 16'd4},
        {2'd2, 3'd1, 2'd2, 9'h0F1, 16'd1},
        {2'd2, 3'd1, 2'd3, 9'h0F3, 16'd5},
        {2'd3, 3'd3, 2'd0, 9'h007, 16'd3},
        {2'd3, 3'd3, 2'd1, 9'h1F0, 16'd12},
        {2'd3, 3'd0, 2'd2, 9'h044, 16'd4},
        {2'd2, 3'd2, 2'd0, 9'h0FE, 16'd7}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_rd = 1'b0;
    logic [1:0]  cmd_bank = '0;
    logic [8:0]  cmd_col = '0;
    logic        mode_wr = 1'b0;
    logic [1:0]  mode_cl = '0;
    logic [2:0]  mode_bl = '0;
    logic [15:0] dq;
    logic        dq_oe;

    int          cyc = 0;
    int          n_chk = 0;
    int          n_bad = 0;
    bit          chk_en = 1'b0;
    bit          done = 1'b0;
    int          cur_cl = 3;
    int          cur_bl = 2;
    int          last_slot = -10;
    bit          exp_v [NSL];
    logic [15:0] exp_d [NSL];
    string       exp_t [NSL];
    logic [15:0] ed;

    rdburst_pipe dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .cmd_rd   (cmd_rd),
        .cmd_bank (cmd_bank),
        .cmd_col  (cmd_col),
        .mode_wr  (mode_wr),
        .mode_cl  (mode_cl),
        .mode_bl  (mode_bl),
        .dq       (dq),
        .dq_oe    (dq_oe)
    );

    always #5 clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    // Expected word per R3.
    function automatic logic [15:0] wexp(input int b, input int c);
        logic [1:0] bb;
        logic [8:0] cc;
        bb = b[1:0];
        cc = c[8:0];
        return {bb, 5'b10101, cc};
    endfunction

    function automatic void clear_sched();
        for (int s = 0; s < NSL; s++) begin
            exp_v[s] = 1'b0;
            exp_d[s] = '0;
            exp_t[s] = "R6";
        end
    endfunction

    // Per-cycle compare of the output against the schedule.
    always @(negedge clk) begin
        if (chk_en && cyc < NSL) begin
            ed = exp_v[cyc] ? exp_d[cyc] : 16'h0;
            n_chk++;
            if (dq_oe !== exp_v[cyc] || dq !== ed) begin
                n_bad++;
                $display("FAIL %s cycle %0d: oe=%0b dq=%h expected oe=%0b dq=%h",
                         exp_t[cyc], cyc, dq_oe, dq, exp_v[cyc], ed);
            end
        end
    end

    task automatic nop(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            cmd_rd  = 1'b0;
            mode_wr = 1'b0;
        end
    endtask

    // Schedule the burst of a READ sampled at edge e (R2, R4, R5, R7).
    task automatic sched(input int e, input int b, input int c, input string tag);
        int start;
        int len;
        int m;
        start = e + cur_cl - 1;
        for (int s = start; s < NSL; s++) begin
            exp_v[s] = 1'b0;
            exp_d[s] = '0;
            exp_t[s] = "R6";
        end
        len = (cur_bl == 7) ? NSL : (1 << cur_bl);
        m   = (cur_bl == 7) ? 511 : (1 << cur_bl) - 1;
        for (int i = 0; i < len && start + i < NSL; i++) begin
            exp_v[start+i] = 1'b1;
            exp_d[start+i] = wexp(b, ((c & ~m) | ((c + i) & m)) & 511);
            exp_t[start+i] = tag;
            last_slot = start + i;
        end
    endtask

    task automatic rd(input int b, input int c, input string tag);
        @(negedge clk);
        cmd_rd   = 1'b1;
        cmd_bank = b[1:0];
        cmd_col  = c[8:0];
        mode_wr  = 1'b0;
        sched(cyc + 1, b, c, tag);
    endtask

    // Mode write; the model follows only when the write must be taken.
    task automatic mwrite(input int cl, input int bl, input bit takes);
        @(negedge clk);
        cmd_rd  = 1'b0;
        mode_wr = 1'b1;
        mode_cl = cl[1:0];
        mode_bl = bl[2:0];
        if (takes) begin
            cur_cl = cl;
            cur_bl = bl;
        end
    endtask

    task automatic wait_idle();
        while (cyc < last_slot + 1) nop(1);
        nop(1);
    endtask

    task automatic do_reset();
        @(negedge clk);
        chk_en  = 1'b0;
        rst_n   = 1'b0;
        cmd_rd  = 1'b0;
        mode_wr = 1'b0;
        nop(3);
        rst_n = 1'b1;
        clear_sched();
        cur_cl = 3;
        cur_bl = 2;
        last_slot = -10;
        n_chk++;
        if (dq_oe !== 1'b0 || dq !== 16'h0) begin
            n_bad++;
            $display("FAIL R1 reset state: oe=%0b dq=%h expected oe=0 dq=0000", dq_oe, dq);
        end
        chk_en = 1'b1;
    endtask

    initial begin
        clear_sched();
        do_reset();
        nop(2);

        // R1: default mode (CL3, four words) is used by the first READ.
        rd(1, 3, "R1");
        wait_idle();

        // Table walk: R4 full bursts, R7 truncations, mode changes when idle.
        for (int v = 0; v < NVEC; v++) begin
            int vcl;
            int vbl;
            int vgap;
            vcl  = int'(VEC[v][31:30]);
            vbl  = int'(VEC[v][29:27]);
            vgap = int'(VEC[v][15:0]);
            if (vcl != cur_cl || vbl != cur_bl) begin
                wait_idle();
                mwrite(vcl, vbl, 1'b1);
            end
            rd(int'(VEC[v][26:25]), int'(VEC[v][24:16]),
               (vgap + 1 < (1 << vbl)) ? "R7" : "R4");
            nop(vgap);
        end
        wait_idle();

        // R2: latency for both settings, single words on a quiet bus.
        mwrite(2, 0, 1'b1);
        rd(2, 77, "R2");
        wait_idle();
        mwrite(3, 0, 1'b1);
        rd(3, 78, "R2");
        wait_idle();

        // R3: word contents across banks and column extremes.
        rd(0, 0, "R3");
        rd(3, 511, "R3");
        rd(2, 256, "R3");
        wait_idle();

        // R8: READs on every cycle to one bank, then alternating banks.
        mwrite(2, 2, 1'b1);
        rd(1, 40, "R8");
        rd(1, 41, "R8");
        rd(1, 42, "R8");
        rd(0, 43, "R8");
        rd(1, 44, "R8");
        nop(1);
        wait_idle();

        // R9: write during a burst is ignored; latency and length stay CL2/4.
        rd(2, 20, "R9");
        mwrite(3, 3, 1'b0);
        nop(6);
        wait_idle();
        rd(2, 21, "R9");
        wait_idle();

        // R9: write on the same edge as a READ is ignored.
        @(negedge clk);
        cmd_rd   = 1'b1;
        cmd_bank = 2'd3;
        cmd_col  = 9'd30;
        mode_wr  = 1'b1;
        mode_cl  = 2'd3;
        mode_bl  = 3'd0;
        sched(cyc + 1, 3, 30, "R9");
        nop(1);
        wait_idle();
        rd(3, 31, "R9");
        wait_idle();

        // R10: reserved length code and illegal latency are ignored.
        mwrite(3, 5, 1'b0);
        nop(2);
        rd(0, 60, "R10");
        wait_idle();
        mwrite(1, 1, 1'b0);
        nop(2);
        rd(0, 64, "R10");
        wait_idle();

        // R5: full page from column 508 wraps past 511 to 0 and keeps going.
        mwrite(3, 7, 1'b1);
        rd(1, 508, "R5");
        nop(530);
        // R7: a new READ cuts the page burst and follows it directly.
        rd(2, 3, "R7");
        nop(12);

        // R1: reset ends the page burst and restores the defaults.
        do_reset();
        nop(2);
        rd(0, 9, "R1");
        wait_idle();
        nop(3);

        chk_en = 1'b0;
        done   = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: run did not complete, actual=hung expected=done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule